// File: doc/BRIEF.md
# Noise-Shaping Error-Feedback Quantizer

This block turns a stream of signed multi-bit samples into a coarse code, one bit wide by default, and pushes the resulting quantization noise away from low frequencies. Each accepted sample is reduced by a weighted sum of earlier quantization errors to form the quantizer input. That value is quantized. The error between the chosen output level and the quantizer input is then stored for the following samples. Because the weights sum to one, the noise transfer has a zero at DC. A long run of output levels therefore averages to the input value.

The block accepts one sample per cycle when `smp_vld` is high and presents the code one cycle later with `code_vld`. Idle cycles leave the loop state untouched. The shaping weights are fixed-point parameters: each one is a signed integer divided by 2^`WFRAC`. The default pair is 1.25 and -0.25, which gives the noise transfer (1 - z^-1)(1 - 0.25 z^-1). A parameter selects either the one-bit threshold quantizer or a multi-bit floor quantizer with clamping.

Top module: `nsq_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `code_vld` is 0, `code` is 0 and every stored error is 0. The first sample after reset is quantized as if all past errors were zero.
- R2: `code_vld` is high in the cycle after each cycle in which `smp_vld` is high, and low otherwise. `code` changes only in those cycles.
- R3: The quantizer input is u = x - floor((sum over k of C_k * e(m-1-k)) / 2^WFRAC). C_k is the signed weight of tap k, and tap 0 holds the most recent error.
- R4: With OUT_W = 1, the code is 1 when u >= 0 and 0 when u < 0. This is a threshold at the mid-point of the two's-complement range.
- R5: With OUT_W = 1, code 1 stands for the level +2^(IN_W-1) and code 0 for -2^(IN_W-1). The stored error is e = level - u.
- R6: A cycle with `smp_vld` low does not shift or alter the error history. Samples separated by idle gaps give the same codes as the same samples back to back.
- R7: With OUT_W > 1, the code is the two's-complement value c = floor(u / 2^(IN_W-OUT_W)), clamped to [-2^(OUT_W-1), 2^(OUT_W-1)-1]. The level is c * 2^(IN_W-OUT_W) and the error is level - u.
- R8: With the default weights, a constant input x held for N samples with one-bit output gives a sum of levels within N + 3*2^(IN_W-1) of N*x.
- R9: For inputs within half of full scale, the error and feedback paths keep exact values (no wrap), so every code matches an unbounded-precision model of R3 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Input sample qualifier |
| smp | input | IN_W | Signed input sample |
| code_vld | output | 1 | Output code qualifier, one cycle after `smp_vld` |
| code | output | OUT_W | Quantized code (two's complement when OUT_W > 1) |

## Verification
The stored error history is the only state in the loop, and every later quantizer input depends on it. A corrupted or wrongly shifted error therefore shows up as a wrong code within one or two accepted samples, once the input moves near a decision threshold. A sign or scaling fault in the feedback gives the same code stream for a while, but it moves the long-run average away from the constant input. Such a fault shows up only over hundreds of samples. An idle cycle that shifts the history misaligns the taps, and the next sample near a threshold exposes it.

// File: rtl/nsq_pkg.sv
package nsq_pkg;

    // Accumulator width for TAPS products of an ERR_W error by a COEF_W weight.
    function automatic int nsq_acc_w(input int err_w, input int coef_w, input int taps);
        return err_w + coef_w + $clog2(taps) + 1;
    endfunction

    // Width of the quantizer input: feedback plus sign-extended sample, one guard bit.
    function automatic int nsq_u_w(input int acc_w, input int in_w);
        return ((acc_w > in_w) ? acc_w : in_w) + 1;
    endfunction

endpackage

// File: rtl/nsq_err_hist.sv
module nsq_err_hist #(
    parameter int TAPS  = 2,
    parameter int ERR_W = 11
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    shift_en,
    input  logic [ERR_W-1:0]        err_in,
    output logic [TAPS*ERR_W-1:0]   hist
);

    logic [ERR_W-1:0] tap_q [TAPS];

    generate
        for (genvar k = 0; k < TAPS; k++) begin : g_tap
            always_ff @(posedge clk) begin
                if (rst) begin
                    tap_q[k] <= '0;
                end else if (shift_en) begin
                    if (k == 0) begin
                        tap_q[k] <= err_in;
                    end else begin
                        tap_q[k] <= tap_q[(k == 0) ? 0 : k-1];
                    end
                end
            end
            assign hist[k*ERR_W +: ERR_W] = tap_q[k];
        end
    endgenerate

endmodule

// File: rtl/nsq_fir.sv
module nsq_fir #(
    parameter int TAPS   = 2,
    parameter int ERR_W  = 11,
    parameter int COEF_W = 6,
    parameter int WFRAC  = 2,
    parameter logic [TAPS*COEF_W-1:0] WEIGHTS = '0,
    parameter int ACC_W  = ERR_W + COEF_W + 2
) (
    input  logic [TAPS*ERR_W-1:0]   hist,
    output logic signed [ACC_W-1:0] fb
);

    localparam int PROD_W = ERR_W + COEF_W;

    logic signed [PROD_W-1:0] prod [TAPS];
    logic signed [ACC_W-1:0]  acc;

    generate
        for (genvar k = 0; k < TAPS; k++) begin : g_mul
            localparam logic signed [COEF_W-1:0] C_K = WEIGHTS[k*COEF_W +: COEF_W];
            assign prod[k] = PROD_W'($signed(hist[k*ERR_W +: ERR_W])) * PROD_W'(C_K);
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++) begin
            acc = acc + ACC_W'(prod[k]);
        end
    end

    // Arithmetic shift gives floor division by 2^WFRAC.
    assign fb = acc >>> WFRAC;

endmodule

// File: rtl/nsq_quant.sv
module nsq_quant #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 1,
    parameter int U_W   = 20,
    parameter int Q_W   = IN_W + 1
) (
    input  logic signed [U_W-1:0] u,
    output logic [OUT_W-1:0]      code,
    output logic signed [Q_W-1:0] level
);

    generate
        if (OUT_W == 1) begin : g_one_bit
            localparam logic signed [Q_W-1:0] LVL_POS = Q_W'(1) <<< (IN_W - 1);
            localparam logic signed [Q_W-1:0] LVL_NEG = -LVL_POS;
            logic non_neg;
            assign non_neg = (u >= 0);
            assign code    = non_neg;
            assign level   = non_neg ? LVL_POS : LVL_NEG;
        end else begin : g_multi_bit
            localparam int SH = IN_W - OUT_W;
            localparam logic signed [U_W-1:0] C_MAX = U_W'((1 <<< (OUT_W - 1)) - 1);
            localparam logic signed [U_W-1:0] C_MIN = -(C_MAX + U_W'(1));
            logic signed [U_W-1:0]   steps;
            logic signed [OUT_W-1:0] c_clip;
            assign steps = u >>> SH;
            always_comb begin
                if (steps > C_MAX) begin
                    c_clip = OUT_W'(C_MAX);
                end else if (steps < C_MIN) begin
                    c_clip = OUT_W'(C_MIN);
                end else begin
                    c_clip = OUT_W'(steps);
                end
            end
            assign code  = c_clip;
            assign level = Q_W'(c_clip) <<< SH;
        end
    endgenerate

endmodule

// File: rtl/nsq_top.sv
module nsq_top
    import nsq_pkg::*;
#(
    parameter int IN_W   = 8,
    parameter int OUT_W  = 1,
    parameter int GUARD  = 3,
    parameter int TAPS   = 2,
    parameter int COEF_W = 6,
    parameter int WFRAC  = 2,
    parameter logic [TAPS*COEF_W-1:0] WEIGHTS = {6'h3F, 6'h05}
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   smp_vld,
    input  logic signed [IN_W-1:0] smp,
    output logic                   code_vld,
    output logic [OUT_W-1:0]       code
);

    localparam int ERR_W = IN_W + GUARD;
    localparam int ACC_W = nsq_acc_w(ERR_W, COEF_W, TAPS);
    localparam int U_W   = nsq_u_w(ACC_W, IN_W);
    localparam int Q_W   = IN_W + 1;

    logic [TAPS*ERR_W-1:0]   hist;
    logic signed [ACC_W-1:0] fb;
    logic signed [U_W-1:0]   u_val;
    logic signed [Q_W-1:0]   level;
    logic [OUT_W-1:0]        code_next;
    logic signed [ERR_W-1:0] err_val;

    nsq_err_hist #(
        .TAPS  (TAPS),
        .ERR_W (ERR_W)
    ) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (smp_vld),
        .err_in   (err_val),
        .hist     (hist)
    );

    nsq_fir #(
        .TAPS    (TAPS),
        .ERR_W   (ERR_W),
        .COEF_W  (COEF_W),
        .WFRAC   (WFRAC),
        .WEIGHTS (WEIGHTS),
        .ACC_W   (ACC_W)
    ) u_fir (
        .hist (hist),
        .fb   (fb)
    );

    assign u_val = U_W'(smp) - U_W'(fb);

    nsq_quant #(
        .IN_W  (IN_W),
        .OUT_W (OUT_W),
        .U_W   (U_W),
        .Q_W   (Q_W)
    ) u_quant (
        .u     (u_val),
        .code  (code_next),
        .level (level)
    );

    // Error kept in ERR_W bits; guard bits cover bounded inputs.
    assign err_val = ERR_W'(level) - ERR_W'(u_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_vld <= 1'b0;
            code     <= '0;
        end else begin
            code_vld <= smp_vld;
            if (smp_vld) begin
                code <= code_next;
            end
        end
    end

endmodule

// File: rtl/nsq_checker.sv
module nsq_checker #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 1,
    parameter int ERR_W = 11,
    parameter int U_W   = 20,
    parameter int TAPS  = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    smp_vld,
    input logic                    code_vld,
    input logic [OUT_W-1:0]        code,
    input logic signed [U_W-1:0]   u_val,
    input logic signed [ERR_W-1:0] err_val,
    input logic [TAPS*ERR_W-1:0]   hist
);

    localparam int FS = 1 << (IN_W - 1);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hist == '0 && !code_vld && code == '0)); // R1

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> code_vld); // R2

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> (!code_vld && $stable(code))); // R2

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(hist)); // R6

    generate
        if (OUT_W == 1) begin : g_one
            AST_THRESHOLD: assert property (@(posedge clk) disable iff (rst)
                smp_vld |=> (code[0] == ($past(u_val) >= 0))); // R4

            AST_ERR_SIDE_POS: assert property (@(posedge clk) disable iff (rst)
                (smp_vld && u_val >= 0 && u_val < U_W'(FS)) |-> (err_val <= ERR_W'(FS) && err_val >= 0)); // R5

            AST_ERR_SIDE_NEG: assert property (@(posedge clk) disable iff (rst)
                (smp_vld && u_val < 0 && u_val > -U_W'(FS)) |-> (err_val < 0 && err_val > -ERR_W'(FS))); // R5
        end else begin : g_multi
            AST_CODE_SIGN: assert property (@(posedge clk) disable iff (rst)
                smp_vld |=> (code[OUT_W-1] == ($past(u_val) < 0))); // R7

            AST_ERR_FLOOR: assert property (@(posedge clk) disable iff (rst)
                (smp_vld && u_val >= 0 && u_val < U_W'(FS/2)) |-> (err_val <= 0 && err_val > -ERR_W'(1 << (IN_W - OUT_W)))); // R7
        end
    endgenerate

endmodule

bind nsq_top nsq_checker #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W),
    .ERR_W (ERR_W),
    .U_W   (U_W),
    .TAPS  (TAPS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_vld  (smp_vld),
    .code_vld (code_vld),
    .code     (code),
    .u_val    (u_val),
    .err_val  (err_val),
    .hist     (hist)
);

// File: tb/nsq_top_tb.sv
`timescale 1ns/1ps
module nsq_top_tb;

    localparam int IN_W = 8;
    localparam int FS   = 1 << (IN_W - 1);

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   smp_vld = 1'b0;
    logic signed [IN_W-1:0] smp = '0;
    logic                   vld1, vld3;
    logic [0:0]             code1;
    logic [2:0]             code3;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int eh [2][2];    // reference error history per DUT, tap 0 newest
    int exp_code [2];
    int exp_lvl  [2];

    always #2.5 clk = ~clk;

    nsq_top #(.IN_W(IN_W), .OUT_W(1)) u_dut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp(smp),
        .code_vld(vld1), .code(code1));

    nsq_top #(.IN_W(IN_W), .OUT_W(3)) u_dut3 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp(smp),
        .code_vld(vld3), .code(code3));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ref_clear();
        for (int d = 0; d < 2; d++) begin
            eh[d][0] = 0;
            eh[d][1] = 0;
        end
    endtask

    // R3/R4/R5/R7 model with unbounded integers.
    task automatic ref_step(input int x);
        for (int d = 0; d < 2; d++) begin
            int acc, f, u, c, q;
            acc = 5 * eh[d][0] - eh[d][1];
            f   = acc >>> 2;
            u   = x - f;
            if (d == 0) begin
                c = (u >= 0) ? 1 : 0;
                q = c ? FS : -FS;
            end else begin
                c = u >>> 5;
                if (c > 3) c = 3;
                if (c < -4) c = -4;
                q = c * 32;
            end
            eh[d][1] = eh[d][0];
            eh[d][0] = q - u;
            exp_code[d] = c & ((d == 0) ? 1 : 7);
            exp_lvl[d]  = q;
        end
    endtask

    task automatic push(input int x, input string tag);
        smp_vld = 1'b1;
        smp     = IN_W'(x);
        ref_step(x);
        @(negedge clk);
        check({tag, " R2 valid"}, int'(vld1), 1);
        check({tag, " one-bit code"}, int'(code1), exp_code[0]);
        check({tag, " R7 multi-bit code"}, int'(code3), exp_code[1]);
    endtask

    task automatic idle(input int n);
        smp_vld = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R2 idle valid low", int'(vld1 | vld3), 0);
            check("R6 idle code held", int'(code1), exp_code[0]);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        int lcg;
        ref_clear();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid in reset", int'(vld1 | vld3), 0);
        check("R1 code in reset", int'(code1) + int'(code3), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", int'(vld1 | vld3), 0);

        // R4 boundary: zero input with empty history gives u = 0 -> code 1
        push(0, "R4 zero threshold");

        // R3/R5/R9: near-exhaustive sweep over half-scale inputs
        for (int x = -FS/2; x <= FS/2; x++) begin
            for (int k = 0; k < 16; k++) push(x, "R3 R5 sweep");
        end

        // R6: same stream with idle gaps of varying length
        lcg = 12345;
        for (int i = 0; i < 2000; i++) begin
            int xv;
            lcg = lcg * 1103515245 + 12345;
            xv  = ((lcg >>> 8) & 32'h7FFF) % (FS + 1) - FS/2;
            push(xv, "R6 R9 gapped");
            if (((lcg >>> 20) & 3) == 0) idle(((lcg >>> 22) & 3) + 1);
        end

        // R1: mid-run reset clears history
        smp_vld = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 valid during mid reset", int'(vld1), 0);
        rst = 1'b0;
        ref_clear();
        @(negedge clk);
        push(-5, "R1 first after reset");
        push(-5, "R1 second after reset");

        // R8: long-run average tracks a constant input
        foreach (exp_lvl[i]) exp_lvl[i] = 0;
        for (int t = 0; t < 5; t++) begin
            int xs [5] = '{-60, -17, 0, 23, 64};
            int sum, dev;
            sum = 0;
            for (int n = 0; n < 1024; n++) begin
                push(xs[t], "R8 dc run");
                sum += (code1 == 1'b1) ? FS : -FS;
            end
            dev = sum - 1024 * xs[t];
            if (dev < 0) dev = -dev;
            check("R8 dc tracking within bound", int'(dev <= 1024 + 3 * FS), 1);
        end

        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule